// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protection Unit

This block holds the status register of a serial EEPROM and decides, for each write request coming from the command front-end, whether it may proceed. It keeps a write-in-progress flag, a write enable latch, a two-bit block-protect field and a status-write-disable bit. It also samples an active-low write-protect pin. The front-end decodes the serial instructions and presents each one as a single-cycle strobe, together with the target address and, for a status write, the new field values. The block answers with a status byte, two allow flags and a busy indication.

An accepted memory write or status write starts a self-timed cycle. The cycle is modelled by a counter of `WRITE_CYCLES` clocks, and the busy flag stays high for the whole count. When the count ends, the busy flag and the write enable latch both clear. The protected area is an adjustable upper part of the array, selected by the block-protect field. When the status-write-disable bit is set and the pin is held low, the unit is in hardware-protected mode and refuses status writes. The status byte stays readable in every cycle, including during a self-timed cycle.

Top module: `eepromGuard`

## Requirements
- R1: After reset (`rstN` low), `statusByte` is 8'h00 and `busy` is 0.
- R2: When idle, a `cmdWren` strobe sets the write enable latch (`statusByte[1]`) on the next clock edge, and a `cmdWrdi` strobe clears it on the next clock edge.
- R3: The `statusByte` layout is: bit 7 = status-write-disable, bits 3:2 = block-protect field, bit 1 = write enable latch, bit 0 = write in progress (equal to `busy`). Bits 6:4 read as 0.
- R4: A `cmdWrite` with `addrAllowed` high starts a cycle. `busy` and bit 0 are high from the next edge for exactly `WRITE_CYCLES` cycles. When the cycle ends, both the write-in-progress flag and the write enable latch are 0.
- R5: A `cmdWrsr` with `srWriteAllowed` high loads `newSrwd` into bit 7 and `newBp` into bits 3:2 on the next edge. It then runs the same self-timed cycle as R4, with the latch cleared at its end.
- R6: With `ADDR_W` address bits, the block-protect field protects: 00 no address, 01 addresses whose top two bits are 11, 10 addresses whose top bit is 1, 11 every address.
- R7: `addrAllowed` = latch set AND not busy AND `addr` not protected. `srWriteAllowed` = latch set AND not busy AND not hardware-protected.
- R8: Hardware-protected mode holds while bit 7 is 1 and `wpN` is 0, whichever of the two became true first. In this mode a `cmdWrsr` is rejected and `statusByte` is unchanged.
- R9: A `cmdWrite` or `cmdWrsr` that is not allowed (latch clear, busy, or protected) is ignored. It starts no cycle and leaves `statusByte` unchanged.
- R10: `cmdWren` and `cmdWrdi` are ignored while busy.
- R11: When several strobes arrive in one cycle, only the first in the order `cmdWrite`, `cmdWrsr`, `cmdWrdi`, `cmdWren` is considered. The others have no effect, even if the chosen one is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWren | input | 1 | Set-write-enable strobe |
| cmdWrdi | input | 1 | Clear-write-enable strobe |
| cmdWrite | input | 1 | Memory write request strobe, target in `addr` |
| cmdWrsr | input | 1 | Status write request strobe |
| newSrwd | input | 1 | Status-write-disable value for a status write |
| newBp | input | 2 | Block-protect value for a status write |
| addr | input | ADDR_W | Target address of a memory write |
| wpN | input | 1 | Write-protect pin, active low |
| statusByte | output | 8 | Status register image |
| addrAllowed | output | 1 | A write to `addr` would be accepted now |
| srWriteAllowed | output | 1 | A status write would be accepted now |
| busy | output | 1 | Self-timed cycle in progress |

## Verification
The allow flags are combinational on `addr`, `wpN` and the registered status, so the bench reads them in the same cycle it drives those inputs. Every strobe acts on the next rising edge. The bench therefore reads the status byte and `busy` a short time after that edge, when all register outputs have settled. A started cycle keeps `busy` high for exactly `WRITE_CYCLES` edges after the accepting edge, and the bench checks this by counting cycles until `busy` falls. A reference model in the bench advances once per edge with the same input values, so each comparison matches the edge count of the design.

// File: rtl/sregPkg.sv
package sregPkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WRITE,
    CMD_WRSR,
    CMD_WRDI,
    CMD_WREN
  } cmdSel_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startCycle;
    logic loadStatus;
    logic endCycle;
  } ctrlStrobe_t;

endpackage

// File: rtl/sregPath.sv
module sregPath
  import sregPkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic              newSrwd,
  input  logic [1:0]        newBp,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wpN,
  output logic [7:0]        statusByte,
  output logic              wel,
  output logic              wip,
  output logic              inProtected,
  output logic              hwLocked
);

  localparam int TOP = ADDR_W - 1;

  logic       srwd;
  logic [1:0] bp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srwd <= 1'b0;
      bp   <= 2'b00;
      wel  <= 1'b0;
      wip  <= 1'b0;
    end else begin
      if (stb.loadStatus) begin
        srwd <= newSrwd;
        bp   <= newBp;
      end
      if (stb.startCycle)    wip <= 1'b1;
      else if (stb.endCycle) wip <= 1'b0;
      if (stb.endCycle || stb.clrWel) wel <= 1'b0;
      else if (stb.setWel)            wel <= 1'b1;
    end
  end

  // Upper-area protection selected by the block-protect field
  always_comb begin
    unique case (bp)
      2'b00:   inProtected = 1'b0;
      2'b01:   inProtected = addr[TOP] & addr[TOP-1];
      2'b10:   inProtected = addr[TOP];
      default: inProtected = 1'b1;
    endcase
  end

  assign hwLocked   = srwd & ~wpN;
  assign statusByte = {srwd, 3'b000, bp, wel, wip};

endmodule

// File: rtl/sregCtrl.sv
module sregCtrl
  import sregPkg::*;
#(
  parameter int WRITE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWren,
  input  logic        cmdWrdi,
  input  logic        cmdWrite,
  input  logic        cmdWrsr,
  input  logic        wel,
  input  logic        wip,
  input  logic        inProtected,
  input  logic        hwLocked,
  output ctrlStrobe_t stb,
  output logic        writeOk,
  output logic        statusOk
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  cmdSel_e         sel;
  logic [CNT_W-1:0] cnt;

  // Fixed priority among simultaneous strobes
  always_comb begin
    if (cmdWrite)     sel = CMD_WRITE;
    else if (cmdWrsr) sel = CMD_WRSR;
    else if (cmdWrdi) sel = CMD_WRDI;
    else if (cmdWren) sel = CMD_WREN;
    else              sel = CMD_NONE;
  end

  assign writeOk  = wel & ~wip & ~inProtected;
  assign statusOk = wel & ~wip & ~hwLocked;

  always_comb begin
    stb            = '0;
    stb.startCycle = ((sel == CMD_WRITE) && writeOk) || ((sel == CMD_WRSR) && statusOk);
    stb.loadStatus = (sel == CMD_WRSR) && statusOk;
    stb.clrWel     = ~wip && (sel == CMD_WRDI);
    stb.setWel     = ~wip && (sel == CMD_WREN);
    stb.endCycle   = wip && (cnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (stb.startCycle)  cnt <= CNT_LOAD;
    else if (cnt != '0)       cnt <= cnt - CNT_LAST;
  end

endmodule

// File: rtl/eepromGuard.sv
module eepromGuard
  import sregPkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int WRITE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrite,
  input  logic              cmdWrsr,
  input  logic              newSrwd,
  input  logic [1:0]        newBp,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wpN,
  output logic [7:0]        statusByte,
  output logic              addrAllowed,
  output logic              srWriteAllowed,
  output logic              busy
);

  ctrlStrobe_t stb;
  logic        wel;
  logic        wip;
  logic        inProtected;
  logic        hwLocked;

  sregCtrl #(.WRITE_CYCLES(WRITE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrite(cmdWrite), .cmdWrsr(cmdWrsr),
    .wel(wel), .wip(wip), .inProtected(inProtected), .hwLocked(hwLocked),
    .stb(stb), .writeOk(addrAllowed), .statusOk(srWriteAllowed)
  );

  sregPath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .newSrwd(newSrwd), .newBp(newBp), .addr(addr), .wpN(wpN),
    .statusByte(statusByte), .wel(wel), .wip(wip),
    .inProtected(inProtected), .hwLocked(hwLocked)
  );

  assign busy = wip;

endmodule

// File: rtl/eepromGuardChk.sv
module eepromGuardChk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWrite,
  input logic       cmdWrsr,
  input logic       wpN,
  input logic [1:0] addrTop,
  input logic       srwdBit,
  input logic [1:0] bpBits,
  input logic       welBit,
  input logic       busy,
  input logic       addrAllowed,
  input logic       srWriteAllowed
);

  assert_cycle_end_wel_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !welBit);

  assert_start_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && addrAllowed) |=> busy);

  assert_all_protected_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bpBits == 2'b11) |-> !addrAllowed);

  assert_quarter_protected_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bpBits == 2'b01 && addrTop == 2'b11) |-> !addrAllowed);

  assert_allow_needs_wel_R7: assert property (@(posedge clk) disable iff (!rstN)
    (addrAllowed || srWriteAllowed) |-> (welBit && !busy));

  assert_hw_lock_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && !cmdWrite && !busy && srwdBit && !wpN)
      |=> ($stable(srwdBit) && $stable(bpBits) && $stable(welBit) && !busy));

  assert_write_no_wel_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !welBit && !busy)
      |=> ($stable(srwdBit) && $stable(bpBits) && $stable(welBit) && !busy));

endmodule

bind eepromGuard eepromGuardChk uChk (
  .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdWrsr(cmdWrsr), .wpN(wpN),
  .addrTop(addr[ADDR_W-1 -: 2]), .srwdBit(statusByte[7]), .bpBits(statusByte[3:2]),
  .welBit(statusByte[1]), .busy(busy), .addrAllowed(addrAllowed),
  .srWriteAllowed(srWriteAllowed)
);

// File: tb/sim_eepromGuard.sv
module sim_eepromGuard;

  localparam int AW = 15;
  localparam int WC = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdWren = 1'b0, cmdWrdi = 1'b0, cmdWrite = 1'b0, cmdWrsr = 1'b0;
  logic          newSrwd = 1'b0;
  logic [1:0]    newBp = 2'b00;
  logic [AW-1:0] addr = '0;
  logic          wpN = 1'b1;
  logic [7:0]    statusByte;
  logic          addrAllowed, srWriteAllowed, busy;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic       mSrwd = 1'b0, mWel = 1'b0, mWip = 1'b0;
  logic [1:0] mBp = 2'b00;
  int         mCnt = 0;

  always #4 clk = ~clk;

  eepromGuard #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi),
    .cmdWrite(cmdWrite), .cmdWrsr(cmdWrsr), .newSrwd(newSrwd), .newBp(newBp),
    .addr(addr), .wpN(wpN), .statusByte(statusByte), .addrAllowed(addrAllowed),
    .srWriteAllowed(srWriteAllowed), .busy(busy)
  );

  function automatic logic protHit(logic [1:0] b, logic [AW-1:0] a);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1] & a[AW-2];
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] mStatus();
    return {mSrwd, 3'b000, mBp, mWel, mWip};
  endfunction

  function automatic logic mAddrOk();
    return mWel & ~mWip & ~protHit(mBp, addr);
  endfunction

  function automatic logic mSrOk();
    return mWel & ~mWip & ~(mSrwd & ~wpN);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    if (mWip) begin
      if (mCnt == 1) begin mWip = 1'b0; mWel = 1'b0; mCnt = 0; end
      else mCnt--;
    end else if (cmdWrite) begin
      if (mAddrOk()) begin mWip = 1'b1; mCnt = WC; end
    end else if (cmdWrsr) begin
      if (mSrOk()) begin mSrwd = newSrwd; mBp = newBp; mWip = 1'b1; mCnt = WC; end
    end else if (cmdWrdi) mWel = 1'b0;
    else if (cmdWren) mWel = 1'b1;
  endtask

  // one clock: drive, compare against model, take the edge, advance model
  task automatic cyc(input logic we, input logic wd, input logic wr, input logic ws,
                     input logic sd, input logic [1:0] bd, input logic [AW-1:0] a,
                     input logic wp);
    cmdWren = we; cmdWrdi = wd; cmdWrite = wr; cmdWrsr = ws;
    newSrwd = sd; newBp = bd; addr = a; wpN = wp;
    #1;
    chk("R3 status byte", 32'(statusByte), 32'(mStatus()));
    chk("R4 busy", 32'(busy), 32'(mWip));
    chk("R7 addrAllowed", 32'(addrAllowed), 32'(mAddrOk()));
    chk("R8 srWriteAllowed", 32'(srWriteAllowed), 32'(mSrOk()));
    @(posedge clk);
    modelEdge();
    #1;
    cmdWren = 1'b0; cmdWrdi = 1'b0; cmdWrite = 1'b0; cmdWrsr = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 2'b00, addr, wpN);
  endtask

  task automatic setStatus(input logic sd, input logic [1:0] bd);
    cyc(1, 0, 0, 0, 0, 2'b00, addr, 1'b1);
    cyc(0, 0, 0, 1, sd, bd, addr, 1'b1);
    idle(WC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", 32'(statusByte), 32'h00);
    chk("R1 reset busy", 32'(busy), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;

    // R2 latch set and clear
    cyc(1, 0, 0, 0, 0, 2'b00, '0, 1'b1);
    chk("R2 wren sets latch", 32'(statusByte[1]), 32'h1);
    cyc(0, 1, 0, 0, 0, 2'b00, '0, 1'b1);
    chk("R2 wrdi clears latch", 32'(statusByte[1]), 32'h0);

    // R9 write with latch clear is ignored
    cyc(0, 0, 1, 0, 0, 2'b00, 15'h0010, 1'b1);
    chk("R9 write without latch", 32'({busy, statusByte}), 32'h000);

    // R4 accepted write, busy length and end state
    cyc(1, 0, 0, 0, 0, 2'b00, 15'h0010, 1'b1);
    cyc(0, 0, 1, 0, 0, 2'b00, 15'h0010, 1'b1);
    chk("R4 write in progress", 32'(statusByte), 32'h03);
    // R10 wrdi during the cycle does not clear the latch
    cyc(0, 1, 0, 0, 0, 2'b00, 15'h0010, 1'b1);
    chk("R10 wrdi while busy", 32'(statusByte[1]), 32'h1);
    n = 1;
    while (busy && n < 100) begin idle(1); n++; end
    chk("R4 busy length", 32'(n), 32'(WC));
    chk("R4 end state", 32'(statusByte), 32'h00);

    // R5 status write loads fields, runs the cycle
    cyc(1, 0, 0, 0, 0, 2'b00, '0, 1'b1);
    cyc(0, 0, 0, 1, 1, 2'b11, '0, 1'b1);
    chk("R5 fields loaded", 32'(statusByte), 32'h8F);
    idle(WC);
    chk("R5 end of status cycle", 32'(statusByte), 32'h8C);

    // R6 everything protected
    cyc(1, 0, 0, 0, 0, 2'b00, 15'h0000, 1'b1);
    chk("R6 bp=11 addr 0", 32'(addrAllowed), 32'h0);
    cyc(0, 0, 1, 0, 0, 2'b00, 15'h0000, 1'b1);
    chk("R9 protected write ignored", 32'({busy, statusByte}), 32'h08E);

    // R8 order 1: disable bit already set, then pin low
    cyc(0, 0, 0, 1, 0, 2'b00, '0, 1'b0);
    chk("R8 locked status write", 32'({busy, statusByte}), 32'h08E);
    cyc(0, 0, 0, 0, 0, 2'b00, '0, 1'b1);
    chk("R8 pin high releases", 32'(srWriteAllowed), 32'h1);
    cyc(0, 0, 0, 1, 0, 2'b01, '0, 1'b1);
    idle(WC);
    chk("R5 bp=01 loaded", 32'(statusByte), 32'h04);

    // R6 quarter boundary
    cyc(1, 0, 0, 0, 0, 2'b00, 15'h5FFF, 1'b1);
    chk("R6 bp=01 below quarter", 32'(addrAllowed), 32'h1);
    addr = 15'h6000; #1;
    chk("R6 bp=01 quarter start", 32'(addrAllowed), 32'h0);
    cyc(0, 1, 0, 0, 0, 2'b00, '0, 1'b1);
    setStatus(0, 2'b10);
    cyc(1, 0, 0, 0, 0, 2'b00, 15'h3FFF, 1'b1);
    chk("R6 bp=10 below half", 32'(addrAllowed), 32'h1);
    addr = 15'h4000; #1;
    chk("R6 bp=10 half start", 32'(addrAllowed), 32'h0);
    setStatus(0, 2'b00);
    cyc(1, 0, 0, 0, 0, 2'b00, 15'h7FFF, 1'b1);
    chk("R6 bp=00 top address", 32'(addrAllowed), 32'h1);
    cyc(0, 1, 0, 0, 0, 2'b00, '0, 1'b1);

    // R8 order 2: pin low first, then disable bit set
    cyc(1, 0, 0, 0, 0, 2'b00, '0, 1'b0);
    cyc(0, 0, 0, 1, 1, 2'b00, '0, 1'b0);
    idle(WC);
    chk("R8 disable bit set under low pin", 32'(statusByte), 32'h80);
    cyc(1, 0, 0, 0, 0, 2'b00, '0, 1'b0);
    chk("R8 locked after pin first", 32'(srWriteAllowed), 32'h0);
    cyc(0, 0, 0, 1, 0, 2'b11, '0, 1'b0);
    chk("R8 rejected status write", 32'(statusByte), 32'h82);
    cyc(0, 0, 0, 1, 0, 2'b00, '0, 1'b1);
    idle(WC);
    chk("R8 unlocked write clears bit", 32'(statusByte), 32'h00);

    // R11 priority
    cyc(1, 1, 0, 0, 0, 2'b00, '0, 1'b1);
    chk("R11 wrdi beats wren", 32'(statusByte[1]), 32'h0);
    cyc(1, 0, 1, 0, 0, 2'b00, '0, 1'b1);
    chk("R11 rejected write blocks wren", 32'(statusByte), 32'h00);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 100) < 30, ($urandom % 100) < 8, ($urandom % 100) < 20,
          ($urandom % 100) < 12, ($urandom % 100) < 30, 2'($urandom),
          AW'($urandom), ($urandom % 100) < 80);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule